// File: doc/BRIEF.md
# USB Packet Transmit Serializer

This block turns a stream of packet bytes into the single-ended line signals of a USB-style transmitter. A packet starts when a byte is offered while the block is idle. It then sends, one bit time per strobe, a synchronisation pattern and the packet bytes with the least significant bit first. An optional CRC follows, and an end-of-packet sequence closes the packet. The serial stream is bit-stuffed and NRZI-encoded before it reaches the line. Stuffed bits are encoded as zeros, so they always create a transition.

The byte source uses a valid/ready handshake and flags the final byte. A two-bit select, sampled when the packet starts, picks no CRC, CRC5 or CRC16. The first byte of a packet is the packet identifier and is not covered by the CRC. The line is advanced only on clock cycles where the bit-time strobe `bit_en` is high. The surrounding logic supplies that strobe at the bit rate. The source is expected to keep the next byte ready before the current one has been shifted out.

Top module: `usbtx_serializer`

## Requirements
- R1: After reset and between packets the line rests in J with output enable low: `line_oe`=0, `line_se0`=0, `line_dp`=1. `in_ready` stays low while idle, even when strobes arrive with no byte offered.
- R2: `line_dp`, `line_se0` and `line_oe` change only on a clock edge where `bit_en` was high.
- R3: On the first strobe while idle with `in_valid` high, `line_oe` rises and the sync byte 0x80 is sent LSB first. On the line this gives the level sequence K J K J K J K K, where K is `line_dp`=0.
- R4: Packet bytes follow the sync field, each sent LSB first. The first byte is excluded from the CRC.
- R5: NRZI: a 0 bit toggles `line_dp`, and a 1 bit leaves it unchanged, so a run of zeros toggles the line on every bit time.
- R6: After six consecutive 1 bits (the last sync bit counts), a stuffed 0 is sent before the next bit and the run count restarts. This also applies when the next symbol is the first SE0 of the end of packet.
- R7: `crc_sel`=00 sends no CRC. `crc_sel`=01 appends CRC5 (x^5+x^2+1). `crc_sel`=1x appends CRC16 (x^16+x^15+x^2+1). In both CRC modes the register starts at all ones, is fed by the data bits in transmit order, and its inverted remainder is sent most significant bit first.
- R8: After the last bit the block sends two bit times of SE0 (`line_se0`=1, `line_dp`=0), then one bit time of J with `line_oe` still high. `line_oe` falls on the next bit time.
- R9: Bytes are taken on cycles where `in_valid` and `in_ready` are both high. After the byte flagged `in_last` is taken, `in_ready` stays low until the packet has ended.
- R10: Changes on `crc_sel` after a packet has started do not affect that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-time strobe; the line advances only on cycles where it is high |
| in_byte | input | 8 | Packet byte |
| in_valid | input | 1 | Byte offered; while idle, requests a new packet |
| in_last | input | 1 | Marks the final byte of the packet |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| crc_sel | input | 2 | CRC choice: 00 none, 01 CRC5, 1x CRC16 |
| line_dp | output | 1 | Line data level, 1 is J |
| line_se0 | output | 1 | Single-ended zero being driven |
| line_oe | output | 1 | Transmitter drives the line |

## Verification
The hardest case to reach from the ports is a run of six ones that ends exactly at the last bit before the end of packet. The stuffed bit must then come before the first SE0 rather than before a data bit. A directed packet whose final byte ends in six ones, with no CRC, forces this case. Packets of all-ones bytes under CRC16 add runs that cross byte boundaries and the sync-to-data boundary. Random packets with random strobe gaps and a `crc_sel` that is scrambled mid-packet cover the remaining mixes.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_PATTERN = 8'h80;
    localparam logic [4:0]  CRC5_POLY  = 5'b00101;
    localparam logic [15:0] CRC16_POLY = 16'h8005;
    localparam int CRC5_LEN  = 5;
    localparam int CRC16_LEN = 16;

    typedef enum logic [1:0] {
        CRC_NONE = 2'd0,
        CRC_5    = 2'd1,
        CRC_16   = 2'd2
    } crc_mode_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_DATA,
        PH_CRC,
        PH_EOP
    } phase_t;

    typedef enum logic [1:0] {
        SYM_IDLE,
        SYM_BIT,
        SYM_SE0,
        SYM_J
    } sym_kind_t;

    // Symbol requested from the sequencer for the next bit time
    typedef struct packed {
        sym_kind_t kind;
        logic      bit_val;
    } sym_req_t;

    // Registered line state
    typedef struct packed {
        logic oe;
        logic se0;
        logic dp;
    } line_t;

    function automatic crc_mode_t decode_crc_sel(input logic [1:0] sel);
        if (sel[1])      return CRC_16;
        else if (sel[0]) return CRC_5;
        else             return CRC_NONE;
    endfunction

    function automatic int crc_len(input crc_mode_t m);
        return (m == CRC_5) ? CRC5_LEN : CRC16_LEN;
    endfunction

    // One serial CRC step, data bit in transmit order
    function automatic logic [15:0] crc_step(input logic [15:0] r,
                                             input crc_mode_t  m,
                                             input logic       d);
        logic [15:0] n;
        logic        fb;
        if (m == CRC_5) begin
            fb = d ^ r[4];
            n  = {11'b0, r[3:0], 1'b0};
            if (fb) n[4:0] = n[4:0] ^ CRC5_POLY;
        end else begin
            fb = d ^ r[15];
            n  = {r[14:0], 1'b0};
            if (fb) n = n ^ CRC16_POLY;
        end
        return n;
    endfunction

endpackage

// File: rtl/usbtx_crc_gen.sv
module usbtx_crc_gen
    import usbtx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  crc_mode_t mode,
    input  logic      upd,
    input  logic      din,
    input  logic      shift,
    output logic      crc_bit
);

    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= crc_step(crc_q, mode, din);
        end else if (shift) begin
            crc_q <= {crc_q[14:0], 1'b1};
        end
    end

    // Inverted remainder, most significant bit of the selected width first
    always_comb begin
        if (mode == CRC_5) crc_bit = ~crc_q[CRC5_LEN-1];
        else               crc_bit = ~crc_q[CRC16_LEN-1];
    end

endmodule

// File: rtl/usbtx_line_enc.sv
module usbtx_line_enc
    import usbtx_pkg::*;
#(
    parameter int STUFF_LIMIT = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  sym_req_t req,
    output logic     take,
    output line_t    line
);

    localparam int CW = $clog2(STUFF_LIMIT + 1);

    logic [CW-1:0] ones_q;
    logic          stall;

    // A stuffed zero pre-empts any data bit or the first SE0
    assign stall = ((req.kind == SYM_BIT) || (req.kind == SYM_SE0)) &&
                   (ones_q == CW'(STUFF_LIMIT));
    assign take  = bit_en && !stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            line   <= '{oe: 1'b0, se0: 1'b0, dp: 1'b1};
            ones_q <= '0;
        end else if (bit_en) begin
            if (stall) begin
                line   <= '{oe: 1'b1, se0: 1'b0, dp: ~line.dp};
                ones_q <= '0;
            end else begin
                case (req.kind)
                    SYM_BIT: begin
                        line.oe  <= 1'b1;
                        line.se0 <= 1'b0;
                        if (req.bit_val) begin
                            ones_q <= ones_q + CW'(1);
                        end else begin
                            line.dp <= ~line.dp;
                            ones_q  <= '0;
                        end
                    end
                    SYM_SE0: begin
                        line   <= '{oe: 1'b1, se0: 1'b1, dp: 1'b0};
                        ones_q <= '0;
                    end
                    SYM_J: begin
                        line   <= '{oe: 1'b1, se0: 1'b0, dp: 1'b1};
                        ones_q <= '0;
                    end
                    default: begin
                        line   <= '{oe: 1'b0, se0: 1'b0, dp: 1'b1};
                        ones_q <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/usbtx_seq.sv
module usbtx_seq
    import usbtx_pkg::*;
#(
    parameter int EOP_SE0_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic [1:0]        crc_sel,
    output sym_req_t          req,
    output crc_mode_t         mode,
    output logic              crc_clear,
    output logic              crc_upd,
    output logic              crc_din,
    output logic              crc_shift,
    input  logic              crc_bit
);

    localparam int BCW = $clog2(BYTE_W);
    localparam int EW  = $clog2(EOP_SE0_LEN + 1);

    phase_t            phase_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BCW-1:0]    bitcnt_q;
    logic [BYTE_W-1:0] hold_q;
    logic              hold_full_q;
    logic              hold_last_q;
    logic              cur_last_q;
    logic              cur_pid_q;
    logic [3:0]        crc_cnt_q;
    logic [EW-1:0]     eop_cnt_q;

    logic accept;
    logic start;
    logic byte_end;

    assign in_ready = ((phase_q == PH_SYNC) || (phase_q == PH_DATA)) &&
                      !hold_full_q && !cur_last_q;
    assign accept   = in_valid && in_ready;
    assign start    = take && (phase_q == PH_IDLE) && in_valid;
    assign byte_end = (bitcnt_q == BCW'(BYTE_W - 1));

    assign crc_clear = start;
    assign crc_upd   = take && (phase_q == PH_DATA) && !cur_pid_q;
    assign crc_din   = sh_q[0];
    assign crc_shift = take && (phase_q == PH_CRC);

    always_comb begin
        req.bit_val = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                req.kind    = in_valid ? SYM_BIT : SYM_IDLE;
                req.bit_val = SYNC_PATTERN[0];
            end
            PH_SYNC, PH_DATA: begin
                req.kind    = SYM_BIT;
                req.bit_val = sh_q[0];
            end
            PH_CRC: begin
                req.kind    = SYM_BIT;
                req.bit_val = crc_bit;
            end
            PH_EOP: begin
                req.kind = (eop_cnt_q < EW'(EOP_SE0_LEN)) ? SYM_SE0 : SYM_J;
            end
            default: req.kind = SYM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            sh_q        <= '0;
            bitcnt_q    <= '0;
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            hold_last_q <= 1'b0;
            cur_last_q  <= 1'b0;
            cur_pid_q   <= 1'b0;
            crc_cnt_q   <= '0;
            eop_cnt_q   <= '0;
            mode        <= CRC_NONE;
        end else begin
            if (accept) begin
                hold_q      <= in_byte;
                hold_full_q <= 1'b1;
                hold_last_q <= in_last;
            end
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q    <= PH_SYNC;
                        sh_q       <= SYNC_PATTERN >> 1;
                        bitcnt_q   <= BCW'(1);
                        mode       <= decode_crc_sel(crc_sel);
                        cur_last_q <= 1'b0;
                        cur_pid_q  <= 1'b0;
                    end
                end
                PH_SYNC, PH_DATA: begin
                    if (take) begin
                        if (byte_end) begin
                            if ((phase_q == PH_DATA) && cur_last_q) begin
                                phase_q    <= (mode == CRC_NONE) ? PH_EOP : PH_CRC;
                                crc_cnt_q  <= '0;
                                eop_cnt_q  <= '0;
                                cur_last_q <= 1'b0;
                            end else begin
                                sh_q        <= hold_q;
                                hold_full_q <= 1'b0;
                                cur_last_q  <= hold_last_q;
                                cur_pid_q   <= (phase_q == PH_SYNC);
                                phase_q     <= PH_DATA;
                            end
                            bitcnt_q <= '0;
                        end else begin
                            sh_q     <= sh_q >> 1;
                            bitcnt_q <= bitcnt_q + BCW'(1);
                        end
                    end
                end
                PH_CRC: begin
                    if (take) begin
                        if (crc_cnt_q == 4'(crc_len(mode) - 1)) begin
                            phase_q   <= PH_EOP;
                            eop_cnt_q <= '0;
                        end else begin
                            crc_cnt_q <= crc_cnt_q + 4'd1;
                        end
                    end
                end
                PH_EOP: begin
                    if (take) begin
                        if (eop_cnt_q == EW'(EOP_SE0_LEN)) phase_q <= PH_IDLE;
                        else eop_cnt_q <= eop_cnt_q + EW'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/usbtx_serializer.sv
module usbtx_serializer
    import usbtx_pkg::*;
#(
    parameter int STUFF_LIMIT = 6,
    parameter int EOP_SE0_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic [1:0]        crc_sel,
    output logic              line_dp,
    output logic              line_se0,
    output logic              line_oe
);

    sym_req_t  req;
    crc_mode_t mode;
    line_t     line;
    logic      take;
    logic      crc_clear;
    logic      crc_upd;
    logic      crc_din;
    logic      crc_shift;
    logic      crc_bit;

    usbtx_seq #(
        .EOP_SE0_LEN(EOP_SE0_LEN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .in_byte  (in_byte),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .crc_sel  (crc_sel),
        .req      (req),
        .mode     (mode),
        .crc_clear(crc_clear),
        .crc_upd  (crc_upd),
        .crc_din  (crc_din),
        .crc_shift(crc_shift),
        .crc_bit  (crc_bit)
    );

    usbtx_crc_gen u_crc (
        .clk    (clk),
        .rst    (rst),
        .clear  (crc_clear),
        .mode   (mode),
        .upd    (crc_upd),
        .din    (crc_din),
        .shift  (crc_shift),
        .crc_bit(crc_bit)
    );

    usbtx_line_enc #(
        .STUFF_LIMIT(STUFF_LIMIT)
    ) u_enc (
        .clk   (clk),
        .rst   (rst),
        .bit_en(bit_en),
        .req   (req),
        .take  (take),
        .line  (line)
    );

    assign line_dp  = line.dp;
    assign line_se0 = line.se0;
    assign line_oe  = line.oe;

endmodule

// File: rtl/usbtx_checker.sv
module usbtx_checker #(
    parameter int STUFF_LIMIT = 6
) (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic in_ready,
    input logic line_dp,
    input logic line_se0,
    input logic line_oe
);

    // Length of the current run of equal driven data levels, in bit times
    logic       en_d;
    logic       was_data;
    logic       last_dp;
    logic [3:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d     <= 1'b0;
            was_data <= 1'b0;
            last_dp  <= 1'b1;
            run      <= '0;
        end else begin
            en_d <= bit_en;
            if (en_d) begin
                if (line_oe && !line_se0) begin
                    if (was_data && (line_dp == last_dp)) begin
                        if (run != 4'hF) run <= run + 4'd1;
                    end else begin
                        run <= 4'd1;
                    end
                    was_data <= 1'b1;
                    last_dp  <= line_dp;
                end else begin
                    was_data <= 1'b0;
                    run      <= '0;
                end
            end
        end
    end

    // R1: idle line is J
    a_r1_idle_is_j: assert property (@(posedge clk) disable iff (rst)
        !line_oe |-> (line_dp && !line_se0));

    // R2: line holds between strobes
    a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable({line_oe, line_se0, line_dp}));

    // R3: first driven symbol is K
    a_r3_packet_opens_with_k: assert property (@(posedge clk) disable iff (rst)
        $rose(line_oe) |-> (!line_dp && !line_se0));

    // R6: a stuffed zero caps every flat run
    a_r6_no_long_flat_run: assert property (@(posedge clk) disable iff (rst)
        run <= 4'(STUFF_LIMIT + 1));

    // R8: SE0 is driven with low data level and enable high
    a_r8_se0_shape: assert property (@(posedge clk) disable iff (rst)
        line_se0 |-> (line_oe && !line_dp));

    // R9: no byte is taken while the line is released
    a_r9_no_ready_when_off: assert property (@(posedge clk) disable iff (rst)
        !line_oe |-> !in_ready);

endmodule

bind usbtx_serializer usbtx_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .in_ready(in_ready),
    .line_dp (line_dp),
    .line_se0(line_se0),
    .line_oe (line_oe)
);

// File: tb/tb_usbtx_serializer.sv
module tb_usbtx_serializer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic [1:0] crc_sel = 2'b00;
    logic       in_ready;
    logic       line_dp;
    logic       line_se0;
    logic       line_oe;

    usbtx_serializer dut (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .in_byte (in_byte),
        .in_valid(in_valid),
        .in_last (in_last),
        .in_ready(in_ready),
        .crc_sel (crc_sel),
        .line_dp (line_dp),
        .line_se0(line_se0),
        .line_oe (line_oe)
    );

    always #10 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  en_gate = 1'b0;

    logic [7:0] pkt[$];
    logic [2:0] exp_q[$];
    logic [2:0] got[$];
    bit         recording = 1'b0;
    bit         rec_done = 1'b0;
    int         viol = 0;
    bit         ready_bad = 1'b0;
    logic [2:0] prev_sym = 3'b001;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Random bit-time strobe, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            bit_en = en_gate && ($urandom_range(0, 2) == 0);
        end
    end

    // Monitor: one symbol {oe,se0,dp} per strobe, plus hold check between strobes
    always @(posedge clk) begin
        logic       en_q;
        logic [2:0] sym;
        en_q = bit_en;
        #5;
        sym = {line_oe, line_se0, line_dp};
        if (!rst && !en_q && (sym !== prev_sym)) viol++;
        prev_sym = sym;
        if (!rst && en_q) begin
            if (!recording && !rec_done && sym[2]) recording = 1'b1;
            if (recording) begin
                got.push_back(sym);
                if (!sym[2]) begin
                    recording = 1'b0;
                    rec_done  = 1'b1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Expected line symbols from the requirements
    task automatic build_exp(input int mode);
        logic        b[$];
        logic        lvl;
        int          ones;
        logic [4:0]  r5;
        logic [15:0] r16;
        logic        fb;
        exp_q.delete();
        for (int k = 0; k < 8; k++) b.push_back(k == 7);
        foreach (pkt[i]) for (int k = 0; k < 8; k++) b.push_back(pkt[i][k]);
        if (mode == 1) begin
            r5 = 5'h1F;
            for (int i = 1; i < pkt.size(); i++)
                for (int k = 0; k < 8; k++) begin
                    fb = pkt[i][k] ^ r5[4];
                    r5 = {r5[3:0], 1'b0};
                    if (fb) r5 = r5 ^ 5'h05;
                end
            for (int k = 4; k >= 0; k--) b.push_back(~r5[k]);
        end else if (mode >= 2) begin
            r16 = 16'hFFFF;
            for (int i = 1; i < pkt.size(); i++)
                for (int k = 0; k < 8; k++) begin
                    fb  = pkt[i][k] ^ r16[15];
                    r16 = {r16[14:0], 1'b0};
                    if (fb) r16 = r16 ^ 16'h8005;
                end
            for (int k = 15; k >= 0; k--) b.push_back(~r16[k]);
        end
        lvl  = 1'b1;
        ones = 0;
        foreach (b[i]) begin
            if (ones == 6) begin
                lvl = ~lvl;
                exp_q.push_back({2'b10, lvl});
                ones = 0;
            end
            if (b[i]) ones++;
            else begin
                lvl  = ~lvl;
                ones = 0;
            end
            exp_q.push_back({2'b10, lvl});
        end
        if (ones == 6) begin
            lvl = ~lvl;
            exp_q.push_back({2'b10, lvl});
        end
        exp_q.push_back(3'b110);
        exp_q.push_back(3'b110);
        exp_q.push_back(3'b101);
        exp_q.push_back(3'b001);
    endtask

    task automatic run_pkt(input int mode, input string tag);
        int bad_idx;
        build_exp(mode);
        got.delete();
        rec_done  = 1'b0;
        viol      = 0;
        ready_bad = 1'b0;
        crc_sel   = 2'(mode);
        foreach (pkt[i]) begin
            in_byte  = pkt[i];
            in_last  = (i == pkt.size() - 1);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            crc_sel = 2'($urandom);   // R10: ignored after start
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (!rec_done) begin
            @(negedge clk);
            if (in_ready) ready_bad = 1'b1;
        end
        // R3: sync field
        bad_idx = -1;
        for (int i = 0; i < 8; i++)
            if (i >= got.size() || got[i] !== exp_q[i]) begin
                if (bad_idx < 0) bad_idx = i;
            end
        chk(bad_idx < 0, "R3", "sync symbol",
            (bad_idx >= 0 && bad_idx < got.size()) ? int'(got[bad_idx]) : -1,
            (bad_idx >= 0) ? int'(exp_q[bad_idx]) : 0);
        // Full sequence
        bad_idx = -1;
        if (got.size() != exp_q.size()) bad_idx = 0;
        else foreach (exp_q[i]) if (got[i] !== exp_q[i] && bad_idx < 0) bad_idx = i;
        if (got.size() != exp_q.size())
            chk(1'b0, tag, "symbol count", got.size(), exp_q.size());
        else
            chk(bad_idx < 0, tag, $sformatf("symbol %0d", bad_idx),
                (bad_idx >= 0) ? int'(got[bad_idx]) : 0,
                (bad_idx >= 0) ? int'(exp_q[bad_idx]) : 0);
        // R8: end of packet shape and release
        if (got.size() >= 4)
            chk(got[got.size()-4] == 3'b110 && got[got.size()-3] == 3'b110 &&
                got[got.size()-2] == 3'b101 && got[got.size()-1] == 3'b001,
                "R8/R1", "end of packet tail",
                int'({got[got.size()-4], got[got.size()-3], got[got.size()-2], got[got.size()-1]}),
                int'({3'b110, 3'b110, 3'b101, 3'b001}));
        else
            chk(1'b0, "R8", "too few symbols", got.size(), 4);
        chk(viol == 0, "R2", "changes without strobe", viol, 0);
        chk(!ready_bad, "R9", "ready after last byte", ready_bad, 0);
    endtask

    initial begin
        int unsigned seed;
        int          len;
        int          mode;
        seed = $urandom(32'd20251);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({line_oe, line_se0, line_dp} == 3'b001, "R1", "line after reset",
            {line_oe, line_se0, line_dp}, 1);
        chk(!in_ready, "R1", "ready after reset", in_ready, 0);
        en_gate = 1'b1;
        repeat (20) @(negedge clk);
        chk({line_oe, line_se0, line_dp} == 3'b001 && !in_ready, "R1",
            "idle with strobes and no byte", {in_ready, line_oe, line_se0, line_dp}, 1);

        // Single identifier byte, no CRC
        pkt = '{8'hD2};
        run_pkt(0, "R4/R5");
        // Zero bytes: toggle every bit time
        pkt = '{8'h4B, 8'h00, 8'h00};
        run_pkt(0, "R5");
        // CRC16 over data bytes
        pkt = '{8'hC3, 8'h00, 8'h01, 8'h5A};
        run_pkt(2, "R4/R7");
        // CRC5 token-like packet
        pkt = '{8'h69, 8'h81, 8'h0A};
        run_pkt(1, "R4/R7");
        // Select 11 behaves as CRC16
        pkt = '{8'hE1, 8'h37};
        run_pkt(3, "R7");
        // Long runs of ones under CRC16
        pkt = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_pkt(2, "R6");
        // Six ones at the very end, stuff before SE0
        pkt = '{8'h00, 8'hFC};
        run_pkt(0, "R6");
        // Empty CRC16 payload
        pkt = '{8'h3C};
        run_pkt(2, "R7");

        for (int n = 0; n < 24; n++) begin
            len  = $urandom_range(1, 8);
            mode = $urandom_range(0, 3);
            pkt.delete();
            for (int i = 0; i < len; i++) pkt.push_back(8'($urandom));
            run_pkt(mode, "R5/R6/R7/R10");
        end

        repeat (10) @(negedge clk);
        chk({line_oe, line_se0, line_dp} == 3'b001, "R1", "idle after traffic",
            {line_oe, line_se0, line_dp}, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule